// File: doc/BRIEF.md
# Secure Configuration Register with Exception Routing

This block holds the security-world control word of a processor core that runs in two security worlds, secure and non-secure. Six bits are stored: a non-secure flag, three routing bits that send the normal interrupt, the fast interrupt and the external abort to monitor mode, and two grant bits that let the non-secure world write the fast-interrupt and abort mask flags of the status register. Software reaches the word through a coprocessor-style port that has a request strobe, a read/write select and the core's current mode. Only the secure privileged world may access it. Any other access leaves the word unchanged and raises an undefined-instruction trap.

The rest of the core reads the stored word through combinational outputs. These give the effective security world, in which monitor mode always counts as secure, the mode that each of the three exceptions enters, and qualified write enables for the two status mask flags. The qualified enables block a mask-flag update from the non-secure world unless the matching grant bit is set.

Top module: `sec_ctrl_reg`

## Requirements
- R1: After reset all six stored bits are 0. A secure privileged read returns 0, the effective world is secure and every exception targets its own mode.
- R2: Bits 5:0 hold, in ascending order, the non-secure flag, interrupt routing, fast-interrupt routing, abort routing, fast-mask write grant and abort-mask write grant. Bit 6 and bits 31:7 always read 0, whatever was written.
- R3: A legal access is secure privileged. A legal read returns the word in the same cycle. A legal write changes the word on the next rising clock edge and not before.
- R4: An access from user mode (10000), or from any non-monitor mode while the non-secure flag is 1, does not change the word, returns 0 as read data, and raises the trap output in the same cycle as the request. The trap is never raised without a request.
- R5: In monitor mode (10110) the effective world is secure and accesses are legal, whatever the value of the non-secure flag. In any other mode the effective world follows the flag.
- R6: When a routing bit is 1, its exception targets monitor mode 10110. When the bit is 0, the exception targets its own mode: interrupt 10010, fast interrupt 10001, abort 10111. This holds in both worlds.
- R7: The fast-mask write enable equals its request, except that it is 0 when the effective world is non-secure and bit 4 is 0.
- R8: The abort-mask write enable equals its request, except that it is 0 when the effective world is non-secure and bit 5 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_mode | input | 5 | Current processor mode field |
| cfg_req | input | 1 | Access request strobe |
| cfg_wr | input | 1 | 1 = write, 0 = read |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, valid in the request cycle |
| cfg_trap | output | 1 | Undefined-instruction trap pulse |
| eff_nonsecure | output | 1 | Effective world is non-secure |
| irq_tgt_mode | output | 5 | Mode entered on a normal interrupt |
| fiq_tgt_mode | output | 5 | Mode entered on a fast interrupt |
| abt_tgt_mode | output | 5 | Mode entered on an external abort |
| fmask_wr_req | input | 1 | Core requests a fast-mask flag write |
| amask_wr_req | input | 1 | Core requests an abort-mask flag write |
| fmask_wr_en | output | 1 | Qualified fast-mask flag write enable |
| amask_wr_en | output | 1 | Qualified abort-mask flag write enable |

## Verification
The trap and the mask-flag gate can act in the same cycle. Non-secure code may try to write grant bits 4 and 5 while it also requests a mask-flag update. The bench provokes this from supervisor mode with the non-secure flag set. It drives an illegal write of both grants together with both mask requests. It then expects the trap to be high, both enables to be low in that cycle and in the next one, and a later monitor-mode read to show the grants still clear.

// File: rtl/sec_ctrl_pkg.sv
package sec_ctrl_pkg;

  localparam int MODE_W   = 5;
  localparam int CFG_BITS = 6;

  localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_MON = 5'b10110;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

  // Packed from MSB to LSB: bit 5 down to bit 0 of the word.
  typedef struct packed {
    logic amask_grant;  // bit 5
    logic fmask_grant;  // bit 4
    logic abt_to_mon;   // bit 3
    logic fiq_to_mon;   // bit 2
    logic irq_to_mon;   // bit 1
    logic nonsec;       // bit 0
  } sec_cfg_t;

  localparam int N_EXC = 3;  // index 0 irq, 1 fiq, 2 abort

  function automatic logic [MODE_W-1:0] home_mode(input int idx);
    case (idx)
      0:       home_mode = MODE_IRQ;
      1:       home_mode = MODE_FIQ;
      default: home_mode = MODE_ABT;
    endcase
  endfunction

endpackage

// File: rtl/sec_ctrl_access.sv
module sec_ctrl_access
  import sec_ctrl_pkg::*;
(
  input  logic [MODE_W-1:0] cpu_mode,
  input  logic              cfg_nonsec,
  input  logic              req,
  input  logic              wr,
  output logic              eff_ns,
  output logic              legal_wr,
  output logic              legal_rd,
  output logic              trap
);

  logic privileged;
  logic in_monitor;
  logic legal;

  always_comb begin
    privileged = (cpu_mode != MODE_USR);
    in_monitor = (cpu_mode == MODE_MON);
    eff_ns     = cfg_nonsec & ~in_monitor;
    legal      = privileged & ~eff_ns;
    legal_wr   = req & wr & legal;
    legal_rd   = req & ~wr & legal;
    trap       = req & ~legal;
  end

endmodule

// File: rtl/sec_ctrl_store.sv
module sec_ctrl_store
  import sec_ctrl_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [CFG_BITS-1:0] wdata,
  output sec_cfg_t            cfg_q
);

  sec_cfg_t cfg_d;

  // Next-state process: load on a legal write, otherwise hold.
  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) begin
      cfg_d = sec_cfg_t'(wdata);
    end
  end

  // Register process with asynchronous active-low reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else begin
      cfg_q <= cfg_d;
    end
  end

endmodule

// File: rtl/sec_ctrl_route.sv
module sec_ctrl_route
  import sec_ctrl_pkg::*;
(
  input  logic [N_EXC-1:0]        to_mon,
  output logic [N_EXC*MODE_W-1:0] tgt_flat
);

  for (genvar g = 0; g < N_EXC; g++) begin : g_exc
    localparam logic [MODE_W-1:0] HOME = home_mode(g);
    always_comb begin
      tgt_flat[g*MODE_W +: MODE_W] = to_mon[g] ? MODE_MON : HOME;
    end
  end

endmodule

// File: rtl/sec_ctrl_maskgate.sv
module sec_ctrl_maskgate #(
  parameter int N_FLAGS = 2
) (
  input  logic               eff_ns,
  input  logic [N_FLAGS-1:0] grant,
  input  logic [N_FLAGS-1:0] req,
  output logic [N_FLAGS-1:0] en
);

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    always_comb begin
      en[g] = req[g] & (~eff_ns | grant[g]);
    end
  end

endmodule

// File: rtl/sec_ctrl_reg.sv
module sec_ctrl_reg
  import sec_ctrl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] cpu_mode,
  input  logic              cfg_req,
  input  logic              cfg_wr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              cfg_trap,
  output logic              eff_nonsecure,
  output logic [MODE_W-1:0] irq_tgt_mode,
  output logic [MODE_W-1:0] fiq_tgt_mode,
  output logic [MODE_W-1:0] abt_tgt_mode,
  input  logic              fmask_wr_req,
  input  logic              amask_wr_req,
  output logic              fmask_wr_en,
  output logic              amask_wr_en
);

  localparam int PAD_W = DATA_W - CFG_BITS;

  sec_cfg_t                cfg_q;
  logic                    legal_wr;
  logic                    legal_rd;
  logic [N_EXC*MODE_W-1:0] tgt_flat;
  logic [1:0]              mask_en;
  logic                    unused_wdata_hi;

  // Reserved write bits are discarded; reads of them return zero.
  assign unused_wdata_hi = ^cfg_wdata[DATA_W-1:CFG_BITS];

  sec_ctrl_access u_access (
    .cpu_mode   (cpu_mode),
    .cfg_nonsec (cfg_q.nonsec),
    .req        (cfg_req),
    .wr         (cfg_wr),
    .eff_ns     (eff_nonsecure),
    .legal_wr   (legal_wr),
    .legal_rd   (legal_rd),
    .trap       (cfg_trap)
  );

  sec_ctrl_store u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (legal_wr),
    .wdata (cfg_wdata[CFG_BITS-1:0]),
    .cfg_q (cfg_q)
  );

  sec_ctrl_route u_route (
    .to_mon   ({cfg_q.abt_to_mon, cfg_q.fiq_to_mon, cfg_q.irq_to_mon}),
    .tgt_flat (tgt_flat)
  );

  sec_ctrl_maskgate #(.N_FLAGS(2)) u_gate (
    .eff_ns (eff_nonsecure),
    .grant  ({cfg_q.amask_grant, cfg_q.fmask_grant}),
    .req    ({amask_wr_req, fmask_wr_req}),
    .en     (mask_en)
  );

  always_comb begin
    irq_tgt_mode = tgt_flat[0*MODE_W +: MODE_W];
    fiq_tgt_mode = tgt_flat[1*MODE_W +: MODE_W];
    abt_tgt_mode = tgt_flat[2*MODE_W +: MODE_W];
    fmask_wr_en  = mask_en[0];
    amask_wr_en  = mask_en[1];
    cfg_rdata    = legal_rd ? {{PAD_W{1'b0}}, cfg_q} : '0;
  end

endmodule

// File: rtl/sec_ctrl_reg_chk.sv
module sec_ctrl_reg_chk
  import sec_ctrl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic [MODE_W-1:0]   cpu_mode,
  input logic                cfg_req,
  input logic                cfg_wr,
  input logic [DATA_W-1:0]   cfg_wdata,
  input logic [DATA_W-1:0]   cfg_rdata,
  input logic                cfg_trap,
  input logic                eff_nonsecure,
  input logic [MODE_W-1:0]   irq_tgt_mode,
  input logic                fmask_wr_req,
  input logic                amask_wr_req,
  input logic                fmask_wr_en,
  input logic                amask_wr_en,
  input logic [CFG_BITS-1:0] cfg_word
);

  a_r2_reserved_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[DATA_W-1:CFG_BITS] == '0);

  a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && cfg_wr && !cfg_trap) |=> (cfg_word == $past(cfg_wdata[CFG_BITS-1:0])));

  a_r4_trap_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_trap |-> cfg_req);

  a_r4_trap_keeps_word: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_trap |=> $stable(cfg_word));

  a_r4_trap_no_rdata: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_trap |-> (cfg_rdata == '0));

  a_r5_monitor_secure: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_mode == MODE_MON) |-> (!eff_nonsecure && !cfg_trap));

  a_r6_irq_route: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_word[1] |-> (irq_tgt_mode == MODE_MON));

  a_r7_fmask_block: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_nonsecure && !cfg_word[4]) |-> !fmask_wr_en);

  a_r7_fmask_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    fmask_wr_en |-> fmask_wr_req);

  a_r8_amask_block: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_nonsecure && !cfg_word[5]) |-> !amask_wr_en);

  a_r8_amask_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    amask_wr_en |-> amask_wr_req);

endmodule

bind sec_ctrl_reg sec_ctrl_reg_chk #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_mode      (cpu_mode),
  .cfg_req       (cfg_req),
  .cfg_wr        (cfg_wr),
  .cfg_wdata     (cfg_wdata),
  .cfg_rdata     (cfg_rdata),
  .cfg_trap      (cfg_trap),
  .eff_nonsecure (eff_nonsecure),
  .irq_tgt_mode  (irq_tgt_mode),
  .fmask_wr_req  (fmask_wr_req),
  .amask_wr_req  (amask_wr_req),
  .fmask_wr_en   (fmask_wr_en),
  .amask_wr_en   (amask_wr_en),
  .cfg_word      (cfg_q)
);

// File: tb/sim_sec_ctrl_reg.sv
module sim_sec_ctrl_reg;

  localparam int CLK_PERIOD = 10;

  localparam logic [4:0] M_USR = 5'b10000;
  localparam logic [4:0] M_FIQ = 5'b10001;
  localparam logic [4:0] M_IRQ = 5'b10010;
  localparam logic [4:0] M_SVC = 5'b10011;
  localparam logic [4:0] M_MON = 5'b10110;
  localparam logic [4:0] M_ABT = 5'b10111;

  logic        clk;
  logic        rst_n;
  logic [4:0]  cpu_mode;
  logic        cfg_req;
  logic        cfg_wr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        cfg_trap;
  logic        eff_nonsecure;
  logic [4:0]  irq_tgt_mode;
  logic [4:0]  fiq_tgt_mode;
  logic [4:0]  abt_tgt_mode;
  logic        fmask_wr_req;
  logic        amask_wr_req;
  logic        fmask_wr_en;
  logic        amask_wr_en;

  int n_checks;
  int n_fail;

  sec_ctrl_reg u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_mode      (cpu_mode),
    .cfg_req       (cfg_req),
    .cfg_wr        (cfg_wr),
    .cfg_wdata     (cfg_wdata),
    .cfg_rdata     (cfg_rdata),
    .cfg_trap      (cfg_trap),
    .eff_nonsecure (eff_nonsecure),
    .irq_tgt_mode  (irq_tgt_mode),
    .fiq_tgt_mode  (fiq_tgt_mode),
    .abt_tgt_mode  (abt_tgt_mode),
    .fmask_wr_req  (fmask_wr_req),
    .amask_wr_req  (amask_wr_req),
    .fmask_wr_en   (fmask_wr_en),
    .amask_wr_en   (amask_wr_en)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  // One access cycle: drive at a falling edge, sample 1 time unit later,
  // release at the following falling edge (the rising edge in between commits).
  task automatic do_access(input logic [4:0] mode, input logic wr, input logic [31:0] data,
                           output logic [31:0] rd, output logic trap);
    @(negedge clk);
    cpu_mode  = mode;
    cfg_req   = 1'b1;
    cfg_wr    = wr;
    cfg_wdata = data;
    #1;
    rd   = cfg_rdata;
    trap = cfg_trap;
    @(negedge clk);
    cfg_req   = 1'b0;
    cfg_wr    = 1'b0;
    cfg_wdata = '0;
  endtask

  task automatic set_mode(input logic [4:0] mode);
    @(negedge clk);
    cpu_mode = mode;
    #1;
  endtask

  task automatic t_reset;
    logic [31:0] rd;
    logic        tr;
    set_mode(M_SVC);
    check("R1 eff world secure", {31'd0, eff_nonsecure}, 32'd0);
    check("R1 irq target", {27'd0, irq_tgt_mode}, {27'd0, M_IRQ});
    check("R1 fiq target", {27'd0, fiq_tgt_mode}, {27'd0, M_FIQ});
    check("R1 abt target", {27'd0, abt_tgt_mode}, {27'd0, M_ABT});
    check("R4 no trap when idle", {31'd0, cfg_trap}, 32'd0);
    do_access(M_SVC, 1'b0, 32'd0, rd, tr);
    check("R1 reset word", rd, 32'd0);
  endtask

  task automatic t_write_read;
    logic [31:0] rd;
    logic        tr;
    @(negedge clk);
    cpu_mode  = M_SVC;
    cfg_req   = 1'b1;
    cfg_wr    = 1'b1;
    cfg_wdata = 32'h0000_003E;
    #1;
    check("R3 no early effect", {27'd0, irq_tgt_mode}, {27'd0, M_IRQ});
    check("R3 legal write no trap", {31'd0, cfg_trap}, 32'd0);
    @(negedge clk);
    cfg_req = 1'b0;
    cfg_wr  = 1'b0;
    #1;
    check("R6 irq to monitor", {27'd0, irq_tgt_mode}, {27'd0, M_MON});
    check("R6 fiq to monitor", {27'd0, fiq_tgt_mode}, {27'd0, M_MON});
    check("R6 abt to monitor", {27'd0, abt_tgt_mode}, {27'd0, M_MON});
    do_access(M_SVC, 1'b0, 32'd0, rd, tr);
    check("R3 read back", rd, 32'h0000_003E);
  endtask

  task automatic t_reserved;
    logic [31:0] rd;
    logic        tr;
    do_access(M_SYS_or_SVC(), 1'b1, 32'hFFFF_FFEA, rd, tr);
    do_access(M_SVC, 1'b0, 32'd0, rd, tr);
    check("R2 reserved and bit 6 read zero", rd, 32'h0000_002A);
  endtask

  function automatic logic [4:0] M_SYS_or_SVC();
    return 5'b11111;
  endfunction

  task automatic t_illegal_user;
    logic [31:0] rd;
    logic        tr;
    do_access(M_USR, 1'b1, 32'h0000_0015, rd, tr);
    check("R4 user write traps", {31'd0, tr}, 32'd1);
    do_access(M_USR, 1'b0, 32'd0, rd, tr);
    check("R4 user read traps", {31'd0, tr}, 32'd1);
    check("R4 user read data zero", rd, 32'd0);
    do_access(M_SVC, 1'b0, 32'd0, rd, tr);
    check("R4 word unchanged by user", rd, 32'h0000_002A);
  endtask

  task automatic t_monitor;
    logic [31:0] rd;
    logic        tr;
    do_access(M_SVC, 1'b1, 32'h0000_0001, rd, tr);
    set_mode(M_SVC);
    check("R5 flag sets non-secure", {31'd0, eff_nonsecure}, 32'd1);
    set_mode(M_MON);
    check("R5 monitor is secure", {31'd0, eff_nonsecure}, 32'd0);
    do_access(M_SVC, 1'b1, 32'h0000_0000, rd, tr);
    check("R4 non-secure write traps", {31'd0, tr}, 32'd1);
    do_access(M_MON, 1'b0, 32'd0, rd, tr);
    check("R5 monitor read legal", {31'd0, tr}, 32'd0);
    check("R4 word kept after non-secure write", rd, 32'h0000_0001);
  endtask

  task automatic t_routing;
    logic [31:0] rd;
    logic        tr;
    do_access(M_MON, 1'b1, 32'h0000_000B, rd, tr);
    set_mode(M_SVC);
    check("R6 ns irq to monitor", {27'd0, irq_tgt_mode}, {27'd0, M_MON});
    check("R6 ns fiq own mode", {27'd0, fiq_tgt_mode}, {27'd0, M_FIQ});
    check("R6 ns abt to monitor", {27'd0, abt_tgt_mode}, {27'd0, M_MON});
    do_access(M_MON, 1'b1, 32'h0000_0004, rd, tr);
    set_mode(M_SVC);
    check("R6 s irq own mode", {27'd0, irq_tgt_mode}, {27'd0, M_IRQ});
    check("R6 s fiq to monitor", {27'd0, fiq_tgt_mode}, {27'd0, M_MON});
    check("R6 s abt own mode", {27'd0, abt_tgt_mode}, {27'd0, M_ABT});
  endtask

  task automatic t_mask_gate;
    logic [31:0] rd;
    logic        tr;
    fmask_wr_req = 1'b1;
    amask_wr_req = 1'b1;
    do_access(M_MON, 1'b1, 32'h0000_0001, rd, tr);
    set_mode(M_SVC);
    check("R7 ns fmask blocked", {31'd0, fmask_wr_en}, 32'd0);
    check("R8 ns amask blocked", {31'd0, amask_wr_en}, 32'd0);
    set_mode(M_MON);
    check("R7 monitor fmask passes", {31'd0, fmask_wr_en}, 32'd1);
    check("R8 monitor amask passes", {31'd0, amask_wr_en}, 32'd1);
    do_access(M_MON, 1'b1, 32'h0000_0011, rd, tr);
    set_mode(M_SVC);
    check("R7 grant opens fmask", {31'd0, fmask_wr_en}, 32'd1);
    check("R8 amask still blocked", {31'd0, amask_wr_en}, 32'd0);
    do_access(M_MON, 1'b1, 32'h0000_0021, rd, tr);
    set_mode(M_SVC);
    check("R7 fmask blocked again", {31'd0, fmask_wr_en}, 32'd0);
    check("R8 grant opens amask", {31'd0, amask_wr_en}, 32'd1);
    do_access(M_MON, 1'b1, 32'h0000_0000, rd, tr);
    set_mode(M_SVC);
    check("R7 secure fmask passes", {31'd0, fmask_wr_en}, 32'd1);
    check("R8 secure amask passes", {31'd0, amask_wr_en}, 32'd1);
    @(negedge clk);
    fmask_wr_req = 1'b0;
    amask_wr_req = 1'b0;
    #1;
    check("R7 no req no enable", {31'd0, fmask_wr_en}, 32'd0);
    check("R8 no req no enable", {31'd0, amask_wr_en}, 32'd0);
  endtask

  task automatic t_same_cycle;
    logic [31:0] rd;
    logic        tr;
    do_access(M_MON, 1'b1, 32'h0000_0001, rd, tr);
    @(negedge clk);
    cpu_mode     = M_SVC;
    fmask_wr_req = 1'b1;
    amask_wr_req = 1'b1;
    cfg_req      = 1'b1;
    cfg_wr       = 1'b1;
    cfg_wdata    = 32'h0000_0031;
    #1;
    check("R4 grant write traps", {31'd0, cfg_trap}, 32'd1);
    check("R7 fmask blocked same cycle", {31'd0, fmask_wr_en}, 32'd0);
    check("R8 amask blocked same cycle", {31'd0, amask_wr_en}, 32'd0);
    @(negedge clk);
    cfg_req   = 1'b0;
    cfg_wr    = 1'b0;
    cfg_wdata = '0;
    #1;
    check("R7 fmask blocked next cycle", {31'd0, fmask_wr_en}, 32'd0);
    check("R8 amask blocked next cycle", {31'd0, amask_wr_en}, 32'd0);
    fmask_wr_req = 1'b0;
    amask_wr_req = 1'b0;
    do_access(M_MON, 1'b0, 32'd0, rd, tr);
    check("R4 grants still clear", rd, 32'h0000_0001);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    n_checks     = 0;
    n_fail       = 0;
    rst_n        = 1'b0;
    cpu_mode     = M_SVC;
    cfg_req      = 1'b0;
    cfg_wr       = 1'b0;
    cfg_wdata    = '0;
    fmask_wr_req = 1'b0;
    amask_wr_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_read();
    t_reserved();
    t_illegal_user();
    t_monitor();
    t_routing();
    t_mask_gate();
    t_same_cycle();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule